// File: doc/BRIEF.md
# Multi-Channel Amplitude Ramp Controller

The block drives several output channels, each holding a 5-bit amplitude code for a downstream DAC or PWM stage. The code runs in linear steps from zero (code 0) up to full scale (code 31). A channel never jumps straight to a new setting. It walks one code at a time toward its goal, at a pace set by that channel's own 3-bit ramp-time code. Every step is gated by a tick enable that is derived from the system clock.

A global output enable selects the goal. While it is high, each channel heads for its own target. While it is low, every channel fades to zero at its own programmed pace. The targets stay held at the inputs, so when the enable returns, each channel climbs back to the target it had before. A per-channel flag shows when the output code equals its current goal. A new target that arrives during a ramp turns the ramp around from the code currently being output.

Top module: `amp_ramp_ctrl`

## Requirements
- R1: While reset is asserted, every channel's amplitude code is 0, and its at-target flag is 1 exactly when its goal is 0.
- R2: Each step moves a channel's code by exactly one toward its goal. A channel never passes its goal, and it holds its code once the goal is reached.
- R3: Channel c's ramp-time code sits in bits [3c+2:3c] of the ramp-time bus. Code 0 gives one step per tick. Codes 1, 2, 3, 4, 5, 6 and 7 give one step every M x STEP_UNIT ticks, where M is 1, 2, 4, 8, 12, 16 and 32 respectively. A full 31-code swing therefore takes a time in the proportion 62.5 : 125 : 250 : 500 : 750 : 1000 : 2000.
- R4: While the tick input is low, no channel's code changes.
- R5: A target change during a ramp continues the ramp from the present code toward the new target, with no jump.
- R6: While the enable is low, every channel's goal is 0 and it ramps down from its present code at its own rate.
- R7: When the enable rises again, each channel ramps back to the target still present at its target input.
- R8: Channels are independent. Channel c's target sits in bits [5c+4:5c] of the target bus, and its code sits in the same bits of the amplitude bus.
- R9: Bit c of at_target is 1 exactly when channel c's code equals its goal (the target while enabled, 0 while disabled).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Ramp time base enable |
| out_en | input | 1 | Global output enable |
| target | input | NCH*5 | Per-channel target amplitude codes |
| rt_code | input | NCH*3 | Per-channel ramp-time codes |
| amp | output | NCH*5 | Per-channel current amplitude codes |
| at_target | output | NCH | Per-channel code-equals-goal flags |

## Verification
When a channel starts from rest with an interval of N ticks and tick held high, its first step appears at the N-th rising edge after the input change. Every later step follows N edges after the one before it. The at-target flag is combinational from the registered code, so it changes in the same cycle as the code. The bench drives inputs and samples outputs on falling edges. For every cycle of every scenario, it computes each channel's expected code as the start code moved toward the goal by the lesser of floor(k/N) and the distance, where k is the number of edges since the stimulus. It compares that value, and the matching flag, each cycle. Scenarios always begin with every channel at rest, so the prescalers start from zero and this count holds.

// File: rtl/amp_ramp_pkg.sv
package amp_ramp_pkg;
    localparam int RT_W   = 3;
    localparam int CODE_W = 5;
    localparam int FULL_MULT = 32;

    // ticks between two steps for a given ramp-time code
    function automatic int unsigned step_ticks(input logic [RT_W-1:0] code,
                                               input int unsigned unit);
        case (code)
            3'd0:    return 1;
            3'd1:    return unit;
            3'd2:    return 2 * unit;
            3'd3:    return 4 * unit;
            3'd4:    return 8 * unit;
            3'd5:    return 12 * unit;
            3'd6:    return 16 * unit;
            default: return 32 * unit;
        endcase
    endfunction
endpackage

// File: rtl/ramp_prescaler.sv
module ramp_prescaler
    import amp_ramp_pkg::*;
#(
    parameter int unsigned STEP_UNIT = 2016
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            busy,
    input  logic [RT_W-1:0] rt_code,
    output logic            step
);
    localparam int CNT_W = $clog2(FULL_MULT * STEP_UNIT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_st_t;

    pre_st_t          st_d, st_q;
    logic [CNT_W-1:0] last_d;

    always_comb begin
        last_d = CNT_W'(step_ticks(rt_code, STEP_UNIT) - 1);
        st_d   = st_q;
        step   = 1'b0;
        if (!busy) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt >= last_d) begin
                step     = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (st_q.cnt == $past(st_q.cnt)) || (st_q.cnt == '0));
endmodule

// File: rtl/ramp_stepper.sv
module ramp_stepper #(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [CODE_W-1:0] goal,
    output logic [CODE_W-1:0] amp,
    output logic              busy
);
    typedef struct packed {
        logic [CODE_W-1:0] amp;
    } stp_st_t;

    stp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            if (goal > st_q.amp)      st_d.amp = st_q.amp + 1'b1;
            else if (goal < st_q.amp) st_d.amp = st_q.amp - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign amp  = st_q.amp;
    assign busy = (st_q.amp != goal);

    // R2
    step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (amp == $past(amp))
              || ({1'b0, $past(amp)} + 1'b1 == {1'b0, amp})
              || ({1'b0, amp} + 1'b1 == {1'b0, $past(amp)}));
    // R2
    toward_goal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (amp == $past(amp)) || ((amp > $past(amp)) == ($past(goal) > $past(amp))));
    // R2
    hold_at_goal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (amp == goal) |=> (amp == $past(amp)));
endmodule

// File: rtl/amp_ramp_ctrl.sv
module amp_ramp_ctrl
    import amp_ramp_pkg::*;
#(
    parameter int          NCH       = 4,
    parameter int unsigned STEP_UNIT = 2016
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic                   out_en,
    input  logic [NCH*CODE_W-1:0]  target,
    input  logic [NCH*RT_W-1:0]    rt_code,
    output logic [NCH*CODE_W-1:0]  amp,
    output logic [NCH-1:0]         at_target
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [CODE_W-1:0] goal;
        logic [CODE_W-1:0] amp_c;
        logic              busy;
        logic              step;

        assign goal = out_en ? target[c*CODE_W +: CODE_W] : '0;

        ramp_prescaler #(.STEP_UNIT(STEP_UNIT)) u_pre (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .busy    (busy),
            .rt_code (rt_code[c*RT_W +: RT_W]),
            .step    (step)
        );

        ramp_stepper #(.CODE_W(CODE_W)) u_stp (
            .clk   (clk),
            .rst_n (rst_n),
            .step  (step),
            .goal  (goal),
            .amp   (amp_c),
            .busy  (busy)
        );

        assign amp[c*CODE_W +: CODE_W] = amp_c;
        assign at_target[c]            = ~busy;

        // R6
        disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!out_en && at_target[c]) |-> (amp_c == '0));
        // R9
        flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            at_target[c] |-> (amp_c == (out_en ? target[c*CODE_W +: CODE_W] : '0)));
    end
endmodule

// File: tb/amp_ramp_ctrl_test.sv
module amp_ramp_ctrl_test;
    localparam int NCH  = 4;
    localparam int UNIT = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                tick = 1'b1;
    logic                out_en = 1'b1;
    logic [NCH*5-1:0]    target;
    logic [NCH*3-1:0]    rt_code;
    logic [NCH*5-1:0]    amp;
    logic [NCH-1:0]      at_target;

    logic [4:0] tgt_r  [NCH];
    logic [2:0] code_r [NCH];
    int cur [NCH];
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            target[c*5 +: 5]  = tgt_r[c];
            rt_code[c*3 +: 3] = code_r[c];
        end
    end

    amp_ramp_ctrl #(.NCH(NCH), .STEP_UNIT(UNIT)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .out_en(out_en),
        .target(target), .rt_code(rt_code), .amp(amp), .at_target(at_target)
    );

    function automatic int interval(input logic [2:0] code);
        case (code)
            3'd0: return 1;
            3'd1: return UNIT;
            3'd2: return 2 * UNIT;
            3'd3: return 4 * UNIT;
            3'd4: return 8 * UNIT;
            3'd5: return 12 * UNIT;
            3'd6: return 16 * UNIT;
            default: return 32 * UNIT;
        endcase
    endfunction

    function automatic int goal_of(input int c);
        return out_en ? int'(tgt_r[c]) : 0;
    endfunction

    task automatic check(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    // runs k cycles from rest, comparing every channel each cycle
    task automatic run_ramp(input string req, input int cycles);
        int s [NCH];
        int e;
        for (int c = 0; c < NCH; c++) s[c] = cur[c];
        for (int k = 1; k <= cycles; k++) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) begin
                int g = goal_of(c);
                int n = k / interval(code_r[c]);
                int d = (g > s[c]) ? g - s[c] : s[c] - g;
                int mv = (n < d) ? n : d;
                e = (g > s[c]) ? s[c] + mv : s[c] - mv;
                check(req, int'(amp[c*5 +: 5]), e);
                check({req, " flag R9"}, int'(at_target[c]), int'(e == g));
                cur[c] = e;
            end
        end
    endtask

    task automatic set_ch(input int c, input int t, input int code);
        tgt_r[c]  = 5'(t);
        code_r[c] = 3'(code);
    endtask

    task automatic t_reset;
        set_ch(0, 0, 0); set_ch(1, 5, 0); set_ch(2, 0, 0); set_ch(3, 9, 0);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            check("R1 amp", int'(amp[c*5 +: 5]), 0);
            check("R1 flag", int'(at_target[c]), int'(tgt_r[c] == 0));
        end
        for (int c = 0; c < NCH; c++) set_ch(c, 0, 0);
        rst_n = 1'b1;
        for (int c = 0; c < NCH; c++) cur[c] = 0;
        run_ramp("R1 idle", 3);
    endtask

    task automatic t_rates_low;
        set_ch(0, 31, 0); set_ch(1, 20, 1); set_ch(2, 10, 2); set_ch(3, 31, 3);
        run_ramp("R3 R8 low codes", 31 * 4 * UNIT + 4);
    endtask

    task automatic t_rates_high;
        set_ch(0, 27, 4); set_ch(1, 16, 5); set_ch(2, 6, 6); set_ch(3, 29, 7);
        run_ramp("R3 R2 high codes", 4 * 16 * UNIT + 4);
    endtask

    task automatic t_tick_gate;
        tick = 1'b0;
        for (int c = 0; c < NCH; c++) set_ch(c, 0, 0);
        repeat (10) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) check("R4 no tick", int'(amp[c*5 +: 5]), cur[c]);
        end
        tick = 1'b1;
        run_ramp("R4 resume", 34);
    endtask

    task automatic t_redirect;
        for (int c = 0; c < NCH; c++) set_ch(c, 20, 0);
        run_ramp("R5 up", 10);
        for (int c = 0; c < NCH; c++) set_ch(c, 4, 0);
        run_ramp("R5 redirect", 12);
        for (int c = 0; c < NCH; c++) set_ch(c, 25, 0);
        run_ramp("R5 reverse", 24);
    endtask

    task automatic t_disable;
        set_ch(0, 12, 0); set_ch(1, 8, 0); set_ch(2, 31, 0); set_ch(3, 0, 0);
        run_ramp("R6 settle", 32);
        for (int c = 0; c < NCH; c++) code_r[c] = 3'd1;
        code_r[2] = 3'd0;
        out_en = 1'b0;
        run_ramp("R6 fade", 31 * UNIT + 4);
        for (int c = 0; c < NCH; c++) check("R6 target kept", int'(cur[c]), 0);
        out_en = 1'b1;
        run_ramp("R7 restore", 31 * UNIT + 4);
        check("R7 ch0", int'(amp[4:0]), 12);
        check("R7 ch2", int'(amp[14:10]), 31);
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) set_ch(c, 0, 0);
        @(negedge clk);
        t_reset();
        t_rates_low();
        t_rates_high();
        t_tick_gate();
        t_redirect();
        t_disable();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got hung expected finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule